// File: doc/BRIEF.md
# Reset Supervisor with Power-On Source Flag

This block drives the chip-wide active-low reset. Its inputs are a digital supply-good level from an external comparator, a request line from other reset sources, and a one-bit software write port. While the supply-good level is low, reset is held. After the supply recovers, reset stays asserted for a fixed number of clock cycles so that the supply can settle. Only then is it released, together with a one-cycle pulse that tells the core to start execution from address zero.

A small source register can be read at any time. Bit 1 is the power-on flag. It is set by a supply-low period and by a software force. Bit 2 is set by a reset from another source, and all other bits read 0. The power-on flag is also the control for a software reset. Writing 1 to it replays the whole power-up sequence, including the settling timeout. Writing 0 to it does nothing.

The supply-good level serves as the block's own reset. Its state is defined from the first clock edge at which that input is sampled low. The timeout length is the parameter `TIMEOUT_CYCLES`, which must be at least 2.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok_i` is sampled low, from the next edge `rst_n_o` is 0, `restart_o` is 0 and the source register reads 8'h02.
- R2: After `supply_ok_i` goes high, `rst_n_o` stays 0 until the `TIMEOUT_CYCLES`-th consecutive rising edge at which `supply_ok_i` is sampled high, and becomes 1 after that edge.
- R3: If `supply_ok_i` drops before the timeout ends, the count starts again. A full `TIMEOUT_CYCLES` of high samples is again needed after the supply returns.
- R4: A drop of `supply_ok_i` while reset is released asserts `rst_n_o` after the next edge, sets bit 1 of the source register and clears bit 2.
- R5: The source register `src_o` has the power-on flag at bit 1 and the other-source flag at bit 2. Every other bit reads 0, and at most one of the two flags is 1.
- R6: With reset released, a write (`reg_wr_i`=1) with `reg_wbit_i`=1 asserts reset after that edge and holds it for `TIMEOUT_CYCLES` edges. The source register then reads 8'h02.
- R7: A write with `reg_wbit_i`=0 has no effect: `rst_n_o` stays 1 and the source register keeps its value.
- R8: With reset released, `ext_req_i` sampled high asserts `rst_n_o` after that edge. Reset stays asserted for as long as the request is sampled high, with no timeout. The source register then reads 8'h04.
- R9: `restart_o` is 1 for exactly the one cycle after each edge at which `rst_n_o` rises, and 0 otherwise.
- R10: A low supply takes priority over a software force, and a software force takes priority over `ext_req_i`. Writes and requests sampled while `rst_n_o` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| supply_ok_i | input | 1 | Supply above threshold, already synchronised; low acts as reset |
| ext_req_i | input | 1 | Reset request from any other source |
| reg_wr_i | input | 1 | Write strobe for the power-on flag |
| reg_wbit_i | input | 1 | Value written to the power-on flag position |
| src_o | output | REG_W | Reset-source register read value |
| rst_n_o | output | 1 | Active-low chip reset |
| restart_o | output | 1 | One-cycle pulse when reset is released |

## Verification
A corrupted sequencer state or timeout count shows up at the ports as a release of `rst_n_o` at the wrong edge. A count that is off by one moves the rising edge by exactly one cycle relative to the last supply-low sample or the force write, so the edge-exact checks catch it within one timeout. A flag register that holds a wrong value shows on `src_o` on the cycle right after the triggering edge. A lost or doubled restart pulse shows on `restart_o` at the same edge as the release.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    localparam int PORF_BIT = 1;
    localparam int EXTF_BIT = 2;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_RUN  = 2'd1,
        ST_EXT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       rst_n;
        logic       restart;
    } seq_regs_t;

    typedef struct packed {
        logic por;
        logic ext;
    } src_flags_t;

endpackage

// File: rtl/rstsup_timer.sv
module rstsup_timer #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic clk_i,
    input  logic clear_i,
    input  logic count_i,
    output logic expired_o
);
    localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (count_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == LAST);

endmodule

// File: rtl/rstsup_seq.sv
module rstsup_seq
    import rstsup_pkg::*;
(
    input  logic clk_i,
    input  logic supply_ok_i,
    input  logic ext_req_i,
    input  logic force_i,
    input  logic expired_i,
    output logic rst_n_o,
    output logic restart_o,
    output logic tmr_clear_o,
    output logic tmr_count_o,
    output logic evt_por_o,
    output logic evt_ext_o
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.restart = 1'b0;
        tmr_clear_o = 1'b0;
        tmr_count_o = 1'b0;
        evt_por_o   = 1'b0;
        evt_ext_o   = 1'b0;

        if (!supply_ok_i) begin
            // supply below threshold: hold everything, restart the count
            r_d.st      = ST_WAIT;
            r_d.rst_n   = 1'b0;
            tmr_clear_o = 1'b1;
            evt_por_o   = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_WAIT: begin
                    if (expired_i) begin
                        r_d.st      = ST_RUN;
                        r_d.rst_n   = 1'b1;
                        r_d.restart = 1'b1;
                        tmr_clear_o = 1'b1;
                    end else begin
                        tmr_count_o = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (force_i) begin
                        r_d.st      = ST_WAIT;
                        r_d.rst_n   = 1'b0;
                        tmr_clear_o = 1'b1;
                        evt_por_o   = 1'b1;
                    end else if (ext_req_i) begin
                        r_d.st    = ST_EXT;
                        r_d.rst_n = 1'b0;
                        evt_ext_o = 1'b1;
                    end
                end
                ST_EXT: begin
                    if (!ext_req_i) begin
                        r_d.st      = ST_RUN;
                        r_d.rst_n   = 1'b1;
                        r_d.restart = 1'b1;
                    end
                end
                default: begin
                    r_d.st      = ST_WAIT;
                    r_d.rst_n   = 1'b0;
                    tmr_clear_o = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign rst_n_o   = r_q.rst_n;
    assign restart_o = r_q.restart;

endmodule

// File: rtl/rstsup_flags.sv
module rstsup_flags
    import rstsup_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk_i,
    input  logic             evt_por_i,
    input  logic             evt_ext_i,
    output logic [REG_W-1:0] src_o
);
    src_flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (evt_por_i) begin
            f_d.por = 1'b1;
            f_d.ext = 1'b0;
        end else if (evt_ext_i) begin
            f_d.por = 1'b0;
            f_d.ext = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        f_q <= f_d;
    end

    always_comb begin
        src_o           = '0;
        src_o[PORF_BIT] = f_q.por;
        src_o[EXTF_BIT] = f_q.ext;
    end

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rstsup_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16,
    parameter int REG_W          = 8
) (
    input  logic             clk_i,
    input  logic             supply_ok_i,
    input  logic             ext_req_i,
    input  logic             reg_wr_i,
    input  logic             reg_wbit_i,
    output logic [REG_W-1:0] src_o,
    output logic             rst_n_o,
    output logic             restart_o
);
    logic force_req;
    logic tmr_clear, tmr_count, tmr_expired;
    logic evt_por, evt_ext;

    // only a 1 written to the power-on flag position does anything
    assign force_req = reg_wr_i & reg_wbit_i;

    rstsup_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk_i     (clk_i),
        .clear_i   (tmr_clear),
        .count_i   (tmr_count),
        .expired_o (tmr_expired)
    );

    rstsup_seq u_seq (
        .clk_i       (clk_i),
        .supply_ok_i (supply_ok_i),
        .ext_req_i   (ext_req_i),
        .force_i     (force_req),
        .expired_i   (tmr_expired),
        .rst_n_o     (rst_n_o),
        .restart_o   (restart_o),
        .tmr_clear_o (tmr_clear),
        .tmr_count_o (tmr_count),
        .evt_por_o   (evt_por),
        .evt_ext_o   (evt_ext)
    );

    rstsup_flags #(.REG_W(REG_W)) u_flags (
        .clk_i     (clk_i),
        .evt_por_i (evt_por),
        .evt_ext_i (evt_ext),
        .src_o     (src_o)
    );

endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input logic clk_i,
    input logic supply_ok_i,
    input logic ext_req_i,
    input logic reg_wr_i,
    input logic reg_wbit_i,
    input logic por_i,
    input logic ext_i,
    input logic rst_n_o,
    input logic restart_o
);
    localparam int HC_W = $clog2(TIMEOUT_CYCLES + 2);

    logic            seen_q = 1'b0;
    logic [HC_W-1:0] hold_q = '0;

    always_ff @(posedge clk_i) begin
        if (!supply_ok_i) seen_q <= 1'b1;
        if (supply_ok_i && !rst_n_o && por_i) hold_q <= hold_q + HC_W'(1);
        else hold_q <= '0;
    end

    p_supply_low_r1: assert property (@(posedge clk_i) disable iff (!seen_q)
        !supply_ok_i |=> (!rst_n_o && por_i && !ext_i));

    // R2 and R3: every power-on style release follows exactly the full count
    p_timeout_len_r2: assert property (@(posedge clk_i) disable iff (!seen_q)
        ($rose(rst_n_o) && por_i) |-> (hold_q == HC_W'(TIMEOUT_CYCLES)));

    p_drop_in_run_r4: assert property (@(posedge clk_i) disable iff (!seen_q)
        (rst_n_o && !supply_ok_i) |=> (!rst_n_o && por_i && !ext_i));

    p_one_flag_r5: assert property (@(posedge clk_i) disable iff (!seen_q)
        $countones({por_i, ext_i}) <= 1);

    p_write_zero_r7: assert property (@(posedge clk_i) disable iff (!seen_q)
        (rst_n_o && supply_ok_i && reg_wr_i && !reg_wbit_i && !ext_req_i) |=> rst_n_o);

    p_other_src_r8: assert property (@(posedge clk_i) disable iff (!seen_q)
        (rst_n_o && supply_ok_i && ext_req_i && !(reg_wr_i && reg_wbit_i))
        |=> (!rst_n_o && ext_i && !por_i));

    p_restart_at_rise_r9: assert property (@(posedge clk_i) disable iff (!seen_q)
        $rose(rst_n_o) |-> restart_o);

    p_restart_single_r9: assert property (@(posedge clk_i) disable iff (!seen_q)
        restart_o |=> !restart_o);

    p_force_wins_r10: assert property (@(posedge clk_i) disable iff (!seen_q)
        (rst_n_o && supply_ok_i && reg_wr_i && reg_wbit_i) |=> (!rst_n_o && por_i));

endmodule

bind rst_supervisor rst_supervisor_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
    .clk_i       (clk_i),
    .supply_ok_i (supply_ok_i),
    .ext_req_i   (ext_req_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wbit_i  (reg_wbit_i),
    .por_i       (src_o[1]),
    .ext_i       (src_o[2]),
    .rst_n_o     (rst_n_o),
    .restart_o   (restart_o)
);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
    localparam int TMO  = 4;
    localparam int NVEC = 29;

    logic       clk = 1'b0;
    logic       sup = 1'b0, ext = 1'b0, wr = 1'b0, wb = 1'b0;
    logic [7:0] src;
    logic       rstn, rs;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    rst_supervisor #(.TIMEOUT_CYCLES(TMO), .REG_W(8)) dut (
        .clk_i(clk), .supply_ok_i(sup), .ext_req_i(ext), .reg_wr_i(wr),
        .reg_wbit_i(wb), .src_o(src), .rst_n_o(rstn), .restart_o(rs)
    );

    // {sup, ext, wr, wbit, exp_rstn, exp_restart, exp_src[7:0], req[3:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {4'b0000, 2'b00, 8'h02, 4'd1},   // R1 supply low
        {4'b0000, 2'b00, 8'h02, 4'd1},
        {4'b1000, 2'b00, 8'h02, 4'd2},   // R2 counting
        {4'b1000, 2'b00, 8'h02, 4'd2},
        {4'b1000, 2'b00, 8'h02, 4'd2},
        {4'b1000, 2'b11, 8'h02, 4'd2},   // R2 release on 4th edge
        {4'b1000, 2'b10, 8'h02, 4'd9},   // R9 pulse over
        {4'b1010, 2'b10, 8'h02, 4'd7},   // R7 write 0
        {4'b1100, 2'b00, 8'h04, 4'd8},   // R8 other source
        {4'b1000, 2'b11, 8'h04, 4'd8},
        {4'b1000, 2'b10, 8'h04, 4'd9},
        {4'b1011, 2'b00, 8'h02, 4'd6},   // R6 force
        {4'b1100, 2'b00, 8'h02, 4'd10},  // R10 request ignored in reset
        {4'b1000, 2'b00, 8'h02, 4'd6},
        {4'b1000, 2'b00, 8'h02, 4'd6},
        {4'b1000, 2'b11, 8'h02, 4'd6},
        {4'b1111, 2'b00, 8'h02, 4'd10},  // R10 force beats request
        {4'b1000, 2'b00, 8'h02, 4'd3},
        {4'b1000, 2'b00, 8'h02, 4'd3},
        {4'b0000, 2'b00, 8'h02, 4'd3},   // R3 drop mid-count
        {4'b1000, 2'b00, 8'h02, 4'd3},
        {4'b1000, 2'b00, 8'h02, 4'd3},
        {4'b1000, 2'b00, 8'h02, 4'd3},
        {4'b1000, 2'b11, 8'h02, 4'd3},
        {4'b1000, 2'b10, 8'h02, 4'd9},
        {4'b1100, 2'b00, 8'h04, 4'd8},
        {4'b1000, 2'b11, 8'h04, 4'd8},
        {4'b0000, 2'b00, 8'h02, 4'd4},   // R4 drop in run, R5 src value
        {4'b0111, 2'b00, 8'h02, 4'd10}   // R10 supply wins
    };

    task automatic step(input logic s, input logic e, input logic w, input logic b);
        @(negedge clk);
        sup = s; ext = e; wr = w; wb = b;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lows;
        int pulses;
        // table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][17], VEC[i][16], VEC[i][15], VEC[i][14]);
            check($sformatf("R%0d vec%0d rst_n", VEC[i][3:0], i), {7'b0, rstn}, {7'b0, VEC[i][13]});
            check($sformatf("R%0d vec%0d restart", VEC[i][3:0], i), {7'b0, rs}, {7'b0, VEC[i][12]});
            check($sformatf("R5 vec%0d src", i), src, VEC[i][11:4]);
        end

        // R2/R9: power-up release edge and one pulse
        repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0);
        lows = 0; pulses = 0;
        for (int k = 0; k < 3 * TMO; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0);
            if (rs) pulses++;
            if (!rstn && pulses == 0) lows++;
        end
        check("R2 low samples after power-up", 8'(lows), 8'(TMO - 1));
        check("R9 pulses after power-up", 8'(pulses), 8'd1);

        // R8: held request, no timeout
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0);
            check("R8 held request rst_n", {7'b0, rstn}, 8'd0);
        end
        step(1'b1, 1'b0, 1'b0, 1'b0);
        check("R8 release rst_n+restart", {6'b0, rstn, rs}, 8'd3);
        check("R8 source", src, 8'h04);

        // R7: write zero repeatedly while running
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b0, 1'b1, 1'b0);
            check("R7 write zero", {6'b0, rstn, rs}, {6'b0, 1'b1, (k == 0) ? 1'b0 : 1'b0});
            check("R7 source kept", src, 8'h04);
        end

        // R6: force holds TMO edges
        step(1'b1, 1'b0, 1'b1, 1'b1);
        lows = (rstn == 1'b0) ? 1 : 0;
        for (int k = 0; k < 2 * TMO; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0);
            if (!rstn) lows++;
        end
        check("R6 force low samples", 8'(lows), 8'(TMO));
        check("R6 source", src, 8'h02);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule